// File: doc/BRIEF.md
# DMA Request Source Multiplexer

This block routes peripheral DMA request lines to the channels of a DMA engine. Each channel owns one configuration byte. The byte holds an enable flag and a 6-bit number that picks one of up to 64 peripheral request inputs. When the slot is enabled, the channel's request output follows the chosen input. When the slot is disabled, the output stays low.

The channels are split evenly across two identical routing banks. Each bank has its own small register window, and a bank-select input chooses which window a write or a read goes to. Inside a window, the byte offset of a slot is its index within that bank. The request outputs are registered once before they leave the block.

Software sets up the route for a channel before it enables requests in the engine. It writes 0x00 to the slot when the channel is released. Reads return the stored setting, so the current routing can be checked.

Top module: `dreq_route_top`

## Requirements
- R1: A configuration byte uses bit 7 as the enable flag and bits 5:0 as the source number. A byte with bit 7 clear disables the slot, whatever its source field holds.
- R2: While a slot is disabled (for example after a write of 0x00), its channel request output is low on every cycle.
- R3: Channel c is served by bank c / (NUM_CH/2) at slot c mod (NUM_CH/2). A write to one bank never changes any configuration held in the other bank.
- R4: In each bank's window, the configuration byte of a slot sits at a byte offset equal to the slot's index within that bank (input `cfg_slot`). A write changes only the addressed slot.
- R5: After reset, every slot reads 0x00 and every channel request output is low.
- R6: When a slot is enabled, its channel request output equals the selected source line as it was sampled at the previous clock edge (one register of latency).
- R7: If an enabled slot is rewritten with a new source number, the output follows the new source from the first clock edge after the write edge. It never shows a mix of old and new values within a cycle.
- R8: Reading a slot returns the last byte written to it, with bit 6 always reading 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration window |
| cfg_bank | input | 1 | Bank select: 0 serves the lower half of the channels, 1 the upper half |
| cfg_slot | input | $clog2(NUM_CH/2) | Byte offset of the slot inside the selected bank window |
| cfg_wdata | input | 8 | Configuration byte to write |
| cfg_rdata | output | 8 | Configuration byte of the addressed slot, bit 6 reads 0 |
| src_req | input | NUM_SRC | Peripheral request lines |
| ch_req | output | NUM_CH | Per-channel request lines to the DMA engine |

## Verification
A corrupted slot register shows in two places. It shows on the read port in the first cycle after the faulty write. It shows on that channel's request output one edge later, as a line that follows the wrong source or stays high while disabled. A wrong bank or slot decode moves a route to a neighbouring channel. Per-channel comparison against a model catches this on the first cycle in which the two sources differ. A missing or extra output register shifts every routed edge by one cycle. Random source patterns expose that within a few cycles.

// File: rtl/dreq_pkg.sv
package dreq_pkg;

  localparam int CFG_BITS = 8;
  localparam int SEL_BITS = 6;
  localparam int EN_POS   = 7;
  localparam logic [CFG_BITS-1:0] CFG_KEEP_MASK = 8'hBF;

  typedef struct packed {
    logic                en;
    logic [SEL_BITS-1:0] sel;
  } slot_cfg_t;

  // Split a written byte into the stored fields; bit 6 is discarded.
  function automatic slot_cfg_t unpack_cfg(input logic [CFG_BITS-1:0] b);
    slot_cfg_t r;
    r.en  = b[EN_POS];
    r.sel = b[SEL_BITS-1:0];
    return r;
  endfunction

  // Rebuild the readable byte from the stored fields.
  function automatic logic [CFG_BITS-1:0] pack_cfg(input slot_cfg_t c);
    return {c.en, 1'b0, c.sel};
  endfunction

endpackage

// File: rtl/dreq_slot.sv
module dreq_slot
  import dreq_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [CFG_BITS-1:0] wr_byte,
  input  logic [NUM_SRC-1:0]  src_req,
  output logic [CFG_BITS-1:0] cfg_byte,
  output logic                req_out
);

  // Select one request line; a number beyond the source count yields 0.
  function automatic logic pick_line(input logic [NUM_SRC-1:0]  v,
                                     input logic [SEL_BITS-1:0] idx);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (idx == SEL_BITS'(i)) r = v[i];
    end
    return r;
  endfunction

  slot_cfg_t cfg_q;
  logic      sel_line;
  logic      gated_req;
  logic      req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= '0;
    else if (wr_en) cfg_q <= unpack_cfg(wr_byte);
  end

  assign sel_line  = pick_line(src_req, cfg_q.sel);
  assign gated_req = cfg_q.en & sel_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= gated_req;
  end

  assign cfg_byte = pack_cfg(cfg_q);
  assign req_out  = req_q;

  // R2: a disabled slot drives no request at the next edge
  assert_disabled_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q.en |=> !req_q);

  // R6: an enabled slot forwards the line sampled one edge earlier
  assert_follow_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.en |=> (req_q == $past(sel_line)));

  // R8: readback equals the written byte with bit 6 cleared
  assert_readback_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cfg_byte == ($past(wr_byte) & CFG_KEEP_MASK)));

endmodule

// File: rtl/dreq_bank.sv
module dreq_bank
  import dreq_pkg::*;
#(
  parameter int SLOTS   = 8,
  parameter int NUM_SRC = 64,
  localparam int AW     = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      win_we,
  input  logic [AW-1:0]             win_addr,
  input  logic [CFG_BITS-1:0]       win_wdata,
  output logic [CFG_BITS-1:0]       win_rdata,
  input  logic [NUM_SRC-1:0]        src_req,
  output logic [SLOTS-1:0]          slot_req,
  output logic [SLOTS*CFG_BITS-1:0] cfg_vec
);

  logic [SLOTS-1:0]    slot_we;
  logic [CFG_BITS-1:0] slot_byte [SLOTS];

  generate
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      assign slot_we[s] = win_we && (win_addr == AW'(s));

      dreq_slot #(.NUM_SRC(NUM_SRC)) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (slot_we[s]),
        .wr_byte  (win_wdata),
        .src_req  (src_req),
        .cfg_byte (slot_byte[s]),
        .req_out  (slot_req[s])
      );

      assign cfg_vec[s*CFG_BITS +: CFG_BITS] = slot_byte[s];
    end
  endgenerate

  always_comb begin
    win_rdata = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (win_addr == AW'(i)) win_rdata = slot_byte[i];
    end
  end

  // R4: a write lands in the slot whose index equals the byte offset
  assert_offset_decode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_we && (int'(win_addr) < SLOTS)) |=>
      (slot_byte[$past(win_addr)] == ($past(win_wdata) & CFG_KEEP_MASK)));

  // R4: at most one slot takes any write
  assert_single_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_we));

endmodule

// File: rtl/dreq_route_top.sv
module dreq_route_top
  import dreq_pkg::*;
#(
  parameter int NUM_CH  = 16,
  parameter int NUM_SRC = 64,
  localparam int NUM_BANKS = 2,
  localparam int SLOTS     = NUM_CH / NUM_BANKS,
  localparam int AW        = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic                cfg_bank,
  input  logic [AW-1:0]       cfg_slot,
  input  logic [CFG_BITS-1:0] cfg_wdata,
  output logic [CFG_BITS-1:0] cfg_rdata,
  input  logic [NUM_SRC-1:0]  src_req,
  output logic [NUM_CH-1:0]   ch_req
);

  logic [SLOTS-1:0]          bank_req [NUM_BANKS];
  logic [SLOTS*CFG_BITS-1:0] bank_cfg [NUM_BANKS];
  logic [CFG_BITS-1:0]       bank_rd  [NUM_BANKS];
  logic [NUM_BANKS-1:0]      bank_we;

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign bank_we[b] = cfg_we && (cfg_bank == 1'(b));

      dreq_bank #(.SLOTS(SLOTS), .NUM_SRC(NUM_SRC)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_we    (bank_we[b]),
        .win_addr  (cfg_slot),
        .win_wdata (cfg_wdata),
        .win_rdata (bank_rd[b]),
        .src_req   (src_req),
        .slot_req  (bank_req[b]),
        .cfg_vec   (bank_cfg[b])
      );

      // channel c = b*SLOTS + slot
      assign ch_req[b*SLOTS +: SLOTS] = bank_req[b];
    end
  endgenerate

  assign cfg_rdata = cfg_bank ? bank_rd[1] : bank_rd[0];

  // R3: writes to the lower bank leave the upper bank untouched
  assert_bank0_isolated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_bank) |=> $stable(bank_cfg[1]));

  // R3: writes to the upper bank leave the lower bank untouched
  assert_bank1_isolated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_bank) |=> $stable(bank_cfg[0]));

endmodule

// File: tb/dreq_route_top_test.sv
`timescale 1ns/1ps
module dreq_route_top_test;

  localparam int NUM_CH  = 16;
  localparam int NUM_SRC = 64;
  localparam int SLOTS   = NUM_CH / 2;
  localparam int AW      = $clog2(SLOTS);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic              cfg_bank = 1'b0;
  logic [AW-1:0]     cfg_slot = '0;
  logic [7:0]        cfg_wdata = '0;
  logic [7:0]        cfg_rdata;
  logic [NUM_SRC-1:0] src_req = '0;
  logic [NUM_CH-1:0] ch_req;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [7:0]        cfg_m [NUM_CH];
  logic [NUM_CH-1:0] q_exp [$];
  string             q_tag [$];
  string             cur_tag = "R5";

  dreq_route_top #(.NUM_CH(NUM_CH), .NUM_SRC(NUM_SRC)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
    .cfg_slot(cfg_slot), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .src_req(src_req), .ch_req(ch_req)
  );

  always #4 clk = ~clk;

  // Expected outputs from the model: enable bit 7, source bits 5:0
  function automatic logic [NUM_CH-1:0] model_out(input logic [NUM_SRC-1:0] s);
    logic [NUM_CH-1:0] r;
    for (int c = 0; c < NUM_CH; c++)
      r[c] = cfg_m[c][7] ? s[int'(cfg_m[c][5:0])] : 1'b0;
    return r;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // Monitor: pops the expected vector for each edge and compares
  always @(posedge clk) begin
    #2;
    if (q_exp.size() > 0) begin
      logic [NUM_CH-1:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      checks++;
      if (ch_req !== e) begin
        failures++;
        $display("FAIL %s: ch_req actual=%04h expected=%04h", t, ch_req, e);
      end
    end
  end

  // Driver: one cycle of stimulus; pushes the output expected after the edge
  task automatic cycle(input bit we, input int ch, input logic [7:0] data,
                       input logic [NUM_SRC-1:0] s);
    @(negedge clk);
    cfg_we    = we;
    cfg_bank  = 1'(ch / SLOTS);
    cfg_slot  = AW'(ch % SLOTS);
    cfg_wdata = data;
    src_req   = s;
    q_exp.push_back(model_out(s));
    q_tag.push_back(cur_tag);
    if (we) cfg_m[ch] = data & 8'hBF;
  endtask

  task automatic wr(input int ch, input logic [7:0] data);
    cycle(1'b1, ch, data, src_req);
  endtask

  task automatic rd_check(input int ch, input logic [7:0] exp, input string tag);
    cycle(1'b0, ch, 8'h00, src_req);
    #1;
    check8(tag, cfg_rdata, exp);
  endtask

  function automatic logic [NUM_SRC-1:0] rnd_src();
    return {$urandom, $urandom};
  endfunction

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    for (int c = 0; c < NUM_CH; c++) cfg_m[c] = 8'h00;
    repeat (3) @(negedge clk);
    // R5: outputs low and all slots read zero while in reset
    checks++;
    if (ch_req !== '0) begin
      failures++;
      $display("FAIL R5: ch_req actual=%04h expected=0000", ch_req);
    end
    @(negedge clk) rst_n = 1'b1;
    for (int c = 0; c < NUM_CH; c++) rd_check(c, 8'h00, "R5 reset readback");

    // R2/R5: all disabled, busy sources
    cur_tag = "R2 disabled";
    for (int i = 0; i < 8; i++) cycle(1'b0, 0, 8'h00, rnd_src());

    // R1/R4/R8: format, offset and bit 6 masking
    cur_tag = "R1 format";
    wr(3, 8'h8A);
    rd_check(3, 8'h8A, "R1 readback ch3");
    wr(12, 8'hCA);
    rd_check(12, 8'h8A, "R8 bit6 masked ch12");
    rd_check(4, 8'h00, "R3 other bank slot4 untouched");
    wr(11, 8'hC5);
    rd_check(3, 8'h8A, "R3 bank0 slot3 untouched by bank1 slot3");
    rd_check(11, 8'h85, "R4 bank1 offset3");

    // R6: routed lines follow random sources
    cur_tag = "R6 follow";
    for (int i = 0; i < 20; i++) cycle(1'b0, 0, 8'h00, rnd_src());

    // R7: change source while enabled, sources toggling
    cur_tag = "R7 reselect";
    cycle(1'b0, 0, 8'h00, 64'h8000_0000_0000_0400);
    cycle(1'b1, 3, 8'hBF, 64'h0000_0000_0000_0400);
    cycle(1'b0, 0, 8'h00, 64'h8000_0000_0000_0000);
    cycle(1'b0, 0, 8'h00, 64'h0000_0000_0000_0400);
    rd_check(3, 8'hBF, "R7 readback new source");

    // R2: 0x00 on ch12 holds low with its old source high
    cur_tag = "R2 cleared";
    wr(12, 8'h00);
    for (int i = 0; i < 4; i++) cycle(1'b0, 0, 8'h00, 64'h0000_0000_0000_0400);
    // R1: source set but enable clear stays low
    cur_tag = "R1 enable clear";
    wr(12, 8'h0A);
    for (int i = 0; i < 4; i++) cycle(1'b0, 0, 8'h00, '1);
    rd_check(12, 8'h0A, "R1 disabled readback");

    // R3/R6: every channel routed to a distinct source
    cur_tag = "R3 mapping";
    for (int c = 0; c < NUM_CH; c++) wr(c, 8'h80 | 8'((c * 5 + 1) % NUM_SRC));
    for (int i = 0; i < 40; i++) cycle(1'b0, 0, 8'h00, rnd_src());
    cur_tag = "R6 walking one";
    for (int i = 0; i < NUM_SRC; i++) cycle(1'b0, 0, 8'h00, 64'h1 << i);
    cycle(1'b0, 0, 8'h00, '0);
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule